// File: doc/BRIEF.md
# Multi-Region Flash Block Erase Engine

This engine clears one erase block of a flash array. The array is split into a fixed number of back-to-back erase regions. Each region has its own block count and its own power-of-two block size. A request carries a byte offset. The engine finds the region that holds that offset, rounds the offset down to a block boundary of that region, and then writes 0xFF to every byte of that block. It writes one byte per clock through a byte-wide memory write port. When the last byte has been written, it pulses `done`.

The same configuration also feeds a small read-only lookup. For each region, the lookup returns the four bytes of the standard query descriptor. A controller that answers flash query reads can fetch these bytes directly from this block.

If the block is built with zero regions, every request erases the whole device array. A request whose offset lies beyond the last region erases nothing and reports an error. The region layout is fixed by parameters, and an illegal layout stops elaboration.

Top module: `ee_block_erase`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_we` are all low.
- R2: Region 0 begins at offset 0. Each later region begins at the end of the one before it, and ends at its start plus block count times block size. A request uses the lowest-numbered region whose end is greater than the offset.
- R3: The first byte written is the offset with its low log2(block size) bits cleared, where the block size is that of the selected region.
- R4: An accepted in-range request writes exactly one block of the selected region. It writes 0xFF to consecutive rising addresses, one byte per cycle. The first write is in the cycle after acceptance. Every byte outside that block keeps its value.
- R5: `busy` is high from the cycle after acceptance through the cycle of the last write. In the cycle after the last write, `done` is high for one cycle, with `err` low and `busy` low.
- R6: A request presented while `busy` is high is ignored. The current erase is unchanged, and no further write or `done` follows.
- R7: A request at an offset not below the end of the last region causes no write. `busy` stays low, and `done` and `err` are both high in the cycle after the request.
- R8: When built with zero regions, every request writes 0xFF to every address from 0 to 2^ADDR_W-1 and then pulses `done`.
- R9: The query lookup returns four bytes for the region on `qry_region`, selected by `qry_byte`. Byte 0 is the low byte and byte 1 the high byte of (block count - 1). Byte 2 is the low byte and byte 3 the high byte of (block size / 256). A region index at or above the configured count returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Erase request strobe |
| req_offset | input | ADDR_W | Byte offset of the erase request |
| busy | output | 1 | Erase in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Offset out of range, valid with done |
| mem_we | output | 1 | Byte write enable to the array |
| mem_addr | output | ADDR_W | Byte write address |
| mem_wdata | output | 8 | Byte write data (always 0xFF) |
| qry_region | input | RIDX_W | Region index for descriptor lookup |
| qry_byte | input | 2 | Descriptor byte select |
| qry_data | output | 8 | Descriptor byte |

## Verification
Two situations are hard to reach from the ports. The first is a request offset that sits exactly on a region boundary: it must pick the following region, not the one it touches. The bench drives the last byte of each region and the first byte of the next. It compares the full memory image against a model, so a wrong region choice or a wrong alignment shows up as changed bytes outside the expected block. The second is a request that arrives during an erase. The bench issues an out-of-range request partway through a fill. It then checks that the write count, the first address and the number of `done` pulses all match a single erase.

// File: rtl/ee_pkg.sv
package ee_pkg;

   localparam int unsigned EE_MAX_REGIONS = 4;

   typedef int unsigned ee_cfg_t [EE_MAX_REGIONS];

   typedef enum logic {
      EE_IDLE = 1'b0,
      EE_FILL = 1'b1
   } ee_state_e;

endpackage

// File: rtl/ee_region_map.sv
module ee_region_map
   import ee_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned NUM_REGIONS = 2,
   parameter ee_cfg_t     REG_BLOCKS  = '{4, 2, 0, 0},
   parameter ee_cfg_t     REG_LOG2    = '{8, 10, 0, 0}
) (
   input  logic [ADDR_W-1:0] offset,
   output logic              hit,
   output logic [ADDR_W-1:0] base,
   output logic [ADDR_W-1:0] last_idx
);

   function automatic ee_cfg_t calc_ends();
      ee_cfg_t     e;
      int unsigned acc;
      acc = 0;
      for (int k = 0; k < EE_MAX_REGIONS; k++) begin
         if (k < NUM_REGIONS) acc = acc + (REG_BLOCKS[k] << REG_LOG2[k]);
         e[k] = acc;
      end
      return e;
   endfunction

   localparam ee_cfg_t ENDS = calc_ends();

   initial begin
      assert (ADDR_W >= 8 && ADDR_W <= 31)
         else $fatal(1, "ADDR_W out of range");
      assert (NUM_REGIONS <= EE_MAX_REGIONS)
         else $fatal(1, "too many regions");
   end

   generate
      if (NUM_REGIONS == 0) begin : g_whole
         // no regions: the whole array is one block
         assign hit      = 1'b1;
         assign base     = '0;
         assign last_idx = '1;
      end else begin : g_regions
         initial begin
            for (int k = 0; k < NUM_REGIONS; k++) begin
               assert (REG_BLOCKS[k] >= 1 && REG_BLOCKS[k] <= 65536)
                  else $fatal(1, "region block count invalid");
               assert (REG_LOG2[k] >= 8 && REG_LOG2[k] <= 23)
                  else $fatal(1, "region block size invalid");
            end
            assert (ENDS[NUM_REGIONS-1] <= (32'd1 << ADDR_W))
               else $fatal(1, "regions exceed device size");
         end

         logic [ADDR_W-1:0] mask;

         // descending scan so the lowest matching region wins
         always_comb begin
            hit  = 1'b0;
            mask = '0;
            for (int k = EE_MAX_REGIONS - 1; k >= 0; k--) begin
               if (k < NUM_REGIONS && 32'(offset) < ENDS[k]) begin
                  hit  = 1'b1;
                  mask = ADDR_W'((32'd1 << REG_LOG2[k]) - 32'd1);
               end
            end
         end

         assign base     = offset & ~mask;
         assign last_idx = mask;
      end
   endgenerate

endmodule

// File: rtl/ee_query_rom.sv
module ee_query_rom
   import ee_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = 2,
   parameter ee_cfg_t     REG_BLOCKS  = '{4, 2, 0, 0},
   parameter ee_cfg_t     REG_LOG2    = '{8, 10, 0, 0},
   parameter int unsigned RIDX_W      = 2
) (
   input  logic [RIDX_W-1:0] region,
   input  logic [1:0]        byte_sel,
   output logic [7:0]        data
);

   logic [31:0] desc [EE_MAX_REGIONS];

   generate
      for (genvar g = 0; g < EE_MAX_REGIONS; g++) begin : g_desc
         localparam logic [15:0] CNT_M1 = (g < NUM_REGIONS) ?
            16'(REG_BLOCKS[g] - 32'd1) : 16'h0000;
         localparam logic [15:0] SZ_PAGES = (g < NUM_REGIONS) ?
            16'((32'd1 << REG_LOG2[g]) >> 8) : 16'h0000;
         // little-endian: count-1 in bytes 0..1, size/256 in bytes 2..3
         assign desc[g] = {SZ_PAGES, CNT_M1};
      end
   endgenerate

   logic [31:0] sel_word;
   assign sel_word = desc[region];

   always_comb begin
      if (32'(region) < NUM_REGIONS) data = sel_word[8*byte_sel +: 8];
      else                           data = 8'h00;
   end

endmodule

// File: rtl/ee_fill_seq.sv
module ee_fill_seq
   import ee_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_err,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] last_idx,
   output logic              busy,
   output logic              we,
   output logic [ADDR_W-1:0] addr,
   output logic              done,
   output logic              err
);

   ee_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] left_q;
   logic              done_q;
   logic              err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= EE_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (state_q)
            EE_IDLE: begin
               if (start) begin
                  if (start_err) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                  end else begin
                     addr_q  <= base;
                     left_q  <= last_idx;
                     state_q <= EE_FILL;
                  end
               end
            end
            EE_FILL: begin
               addr_q <= addr_q + 1'b1;
               left_q <= left_q - 1'b1;
               if (left_q == '0) begin
                  state_q <= EE_IDLE;
                  done_q  <= 1'b1;
               end
            end
            default: state_q <= EE_IDLE;
         endcase
      end
   end

   assign busy = (state_q == EE_FILL);
   assign we   = busy;
   assign addr = addr_q;
   assign done = done_q;
   assign err  = err_q;

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (addr == $past(addr) + 1'b1));

   // R5
   fill_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && !err));

   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7
   err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);

endmodule

// File: rtl/ee_block_erase.sv
module ee_block_erase
   import ee_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned NUM_REGIONS = 2,
   parameter ee_cfg_t     REG_BLOCKS  = '{4, 2, 0, 0},
   parameter ee_cfg_t     REG_LOG2    = '{8, 10, 0, 0},
   localparam int unsigned RIDX_W     = $clog2(EE_MAX_REGIONS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_offset,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [RIDX_W-1:0] qry_region,
   input  logic [1:0]        qry_byte,
   output logic [7:0]        qry_data
);

   logic              hit;
   logic [ADDR_W-1:0] blk_base;
   logic [ADDR_W-1:0] blk_last;
   logic              accept;

   ee_region_map #(
      .ADDR_W      (ADDR_W),
      .NUM_REGIONS (NUM_REGIONS),
      .REG_BLOCKS  (REG_BLOCKS),
      .REG_LOG2    (REG_LOG2)
   ) map_i (
      .offset   (req_offset),
      .hit      (hit),
      .base     (blk_base),
      .last_idx (blk_last)
   );

   assign accept = req_valid && !busy;

   ee_fill_seq #(
      .ADDR_W (ADDR_W)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .start_err (!hit),
      .base      (blk_base),
      .last_idx  (blk_last),
      .busy      (busy),
      .we        (mem_we),
      .addr      (mem_addr),
      .done      (done),
      .err       (err)
   );

   assign mem_wdata = 8'hFF;

   ee_query_rom #(
      .NUM_REGIONS (NUM_REGIONS),
      .REG_BLOCKS  (REG_BLOCKS),
      .REG_LOG2    (REG_LOG2),
      .RIDX_W      (RIDX_W)
   ) rom_i (
      .region   (qry_region),
      .byte_sel (qry_byte),
      .data     (qry_data)
   );

   // R6
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid && $past(busy)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   // R7
   miss_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !hit) |=> (!busy && done && err));

endmodule

// File: tb/ee_block_erase_tb_top.sv
`timescale 1ns/1ps
module ee_block_erase_tb_top;
   import ee_pkg::*;

   localparam int unsigned AW = 12;
   localparam int unsigned NR = 2;
   localparam ee_cfg_t TB_BLOCKS = '{4, 2, 0, 0};
   localparam ee_cfg_t TB_LOG2   = '{8, 10, 0, 0};
   localparam int unsigned ZAW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   // main instance
   logic          req_valid = 1'b0;
   logic [AW-1:0] req_offset = '0;
   logic          busy, done, err, mem_we;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;
   logic [1:0]    qry_region = '0;
   logic [1:0]    qry_byte = '0;
   logic [7:0]    qry_data;

   ee_block_erase #(
      .ADDR_W(AW), .NUM_REGIONS(NR), .REG_BLOCKS(TB_BLOCKS), .REG_LOG2(TB_LOG2)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_offset(req_offset),
      .busy(busy), .done(done), .err(err), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .qry_region(qry_region), .qry_byte(qry_byte),
      .qry_data(qry_data)
   );

   // zero-region instance
   logic           z_req = 1'b0;
   logic [ZAW-1:0] z_off = '0;
   logic           z_busy, z_done, z_err, z_we;
   logic [ZAW-1:0] z_addr;
   logic [7:0]     z_wdata, z_qd;

   ee_block_erase #(
      .ADDR_W(ZAW), .NUM_REGIONS(0), .REG_BLOCKS('{0, 0, 0, 0}), .REG_LOG2('{0, 0, 0, 0})
   ) dut_z_i (
      .clk(clk), .rst_n(rst_n), .req_valid(z_req), .req_offset(z_off),
      .busy(z_busy), .done(z_done), .err(z_err), .mem_we(z_we), .mem_addr(z_addr),
      .mem_wdata(z_wdata), .qry_region(2'd0), .qry_byte(2'd0), .qry_data(z_qd)
   );

   // array models
   logic [7:0] mem   [1 << AW];
   logic [7:0] shadow[1 << AW];
   logic [7:0] zmem  [1 << ZAW];

   always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;
   always @(posedge clk) if (z_we) zmem[z_addr] <= z_wdata;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      int start;
      int len;
      bit err;
   } exp_t;
   exp_t sbq[$];
   int done_count = 0;

   int  wcnt = 0, bcnt = 0, first_a = 0, last_a = 0;
   bit  contig = 1'b1, data_ok = 1'b1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) bcnt++;
         if (mem_we) begin
            if (wcnt == 0) first_a = int'(mem_addr);
            else if (int'(mem_addr) != last_a + 1) contig = 1'b0;
            last_a = int'(mem_addr);
            if (mem_wdata != 8'hFF) data_ok = 1'b0;
            wcnt++;
         end
         if (done) begin
            exp_t e;
            if (sbq.size() == 0) begin
               check(1'b0, "R6 unexpected done", 1, 0);
            end else begin
               e = sbq.pop_front();
               check(err == e.err, "R7 err flag", int'(err), int'(e.err));
               check(wcnt == e.len, "R4 write count", wcnt, e.len);
               check(bcnt == e.len, "R5 busy cycles", bcnt, e.len);
               check(!busy, "R5 busy low with done", int'(busy), 0);
               if (!e.err) begin
                  check(first_a == e.start, "R3 first address", first_a, e.start);
                  check(contig && data_ok, "R4 consecutive 0xFF writes",
                        int'(contig && data_ok), 1);
               end
            end
            wcnt = 0; bcnt = 0; contig = 1'b1; data_ok = 1'b1;
            done_count++;
         end
      end
   end

   // bench region model (R2)
   task automatic model(input int off, output int start, output int len, output bit e);
      int acc = 0;
      e = 1'b1; start = 0; len = 0;
      for (int k = 0; k < NR; k++) begin
         int sz = 1 << TB_LOG2[k];
         acc += TB_BLOCKS[k] * sz;
         if (e && off < acc) begin
            e = 1'b0;
            start = off - (off % sz);
            len = sz;
         end
      end
   endtask

   task automatic erase(input int off, input bit poke);
      exp_t x;
      int n0;
      int mism;
      model(off, x.start, x.len, x.err);
      if (x.err) x.len = 0;
      sbq.push_back(x);
      for (int i = x.start; i < x.start + x.len; i++) shadow[i] = 8'hFF;
      n0 = done_count;
      @(negedge clk);
      req_valid = 1'b1;
      req_offset = AW'(off);
      @(negedge clk);
      req_valid = 1'b0;
      check(busy == !x.err, "R5 busy after accept", int'(busy), int'(!x.err));
      if (poke) begin
         repeat (5) @(negedge clk);
         req_valid = 1'b1;
         req_offset = 12'hC10;
         @(negedge clk);
         req_valid = 1'b0;
      end
      wait (done_count == n0 + 1);
      repeat (4) begin
         @(negedge clk);
         check(!busy && !done && !mem_we, "R6 nothing after done",
               int'({busy, done, mem_we}), 0);
      end
      mism = 0;
      for (int i = 0; i < (1 << AW); i++) if (mem[i] !== shadow[i]) mism++;
      check(mism == 0, "R4 memory image", mism, 0);
   endtask

   task automatic qcheck(input int r, input int b, input int exp);
      @(negedge clk);
      qry_region = 2'(r);
      qry_byte = 2'(b);
      #1;
      check(int'(qry_data) == exp, "R9 query byte", int'(qry_data), exp);
   endtask

   initial begin
      for (int i = 0; i < (1 << AW); i++) begin
         mem[i] = 8'((i * 7 + 3) % 251);
         shadow[i] = mem[i];
      end
      for (int i = 0; i < (1 << ZAW); i++) zmem[i] = 8'(i % 200);
      repeat (3) @(negedge clk);
      check(!busy && !done && !err && !mem_we, "R1 reset outputs",
            int'({busy, done, err, mem_we}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && !err && !mem_we, "R1 idle after reset",
            int'({busy, done, err, mem_we}), 0);

      // R2 R3 R4 region selection and alignment, including boundaries
      erase(32'h2A5, 1'b0);
      erase(32'h000, 1'b1);   // R6 poke while busy
      erase(32'h3FF, 1'b0);
      erase(32'h400, 1'b0);
      erase(32'h9AB, 1'b0);
      erase(32'hBFF, 1'b0);
      // R7 out of range
      erase(32'hC00, 1'b0);
      erase(32'hFFF, 1'b0);

      // R9 descriptors
      qcheck(0, 0, 8'h03); qcheck(0, 1, 8'h00); qcheck(0, 2, 8'h01); qcheck(0, 3, 8'h00);
      qcheck(1, 0, 8'h01); qcheck(1, 1, 8'h00); qcheck(1, 2, 8'h04); qcheck(1, 3, 8'h00);
      qcheck(2, 0, 8'h00); qcheck(3, 2, 8'h00);

      // R8 zero-region build erases the whole array
      begin
         int zw = 0;
         int zbad = 0;
         bit zdone = 1'b0;
         @(negedge clk);
         z_req = 1'b1;
         z_off = 8'h37;
         @(negedge clk);
         z_req = 1'b0;
         while (!zdone) begin
            if (z_we) zw++;
            if (z_done) zdone = 1'b1;
            @(negedge clk);
         end
         for (int i = 0; i < (1 << ZAW); i++) if (zmem[i] !== 8'hFF) zbad++;
         check(zw == (1 << ZAW), "R8 whole-array write count", zw, 1 << ZAW);
         check(zbad == 0, "R8 whole array 0xFF", zbad, 0);
         check(!z_err && z_qd == 8'h00, "R8 no error, empty descriptor",
               int'({z_err, z_qd}), 0);
      end

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule